// File: doc/BRIEF.md
# Drive Timing Sequencer

This block produces the drive-side timing that a disk controller needs around head motion and head engagement. Software writes one parameter word holding three delay codes and a transfer-mode bit: a 4-bit stepping code, a 4-bit release code and a 7-bit engage code. The block then issues step strobes for a requested number of seek steps, spaced at the programmed interval. For a read/write operation it raises a head-engage output and reports readiness once the engage delay has run out. When the operation's execution phase finishes, it holds the head engaged until the release delay runs out.

Every interval is counted in ticks from a shared prescaler. The tick period follows a 3-bit data-rate select, so one code gives a delay that stretches as the rate drops. For the stepping code, larger values give shorter intervals. For the two head codes, a zero code means the largest count. The tick runs freely, so the first interval after a start can be up to one tick shorter than the programmed value. Later step gaps are exact.

Top module: `drv_timing_seq`

## Requirements
- R1: `rate_sel` sets the tick period to BASE_CYC clock cycles times 3, 6, 12, 20 or 24 for codes 0 (2 Mbps), 1 (1 Mbps), 2 (500 kbps), 3 (300 kbps) and 4 (250 kbps). Codes 5 to 7 behave as code 4.
- R2: The step interval is 16 minus the stepping code, in ticks, so code 0 gives 16 ticks. Gaps after the first pulse are exactly that many ticks long. The first pulse comes between one tick less than the interval and the full interval after `seek_start`.
- R3: `seek_start` with count N emits exactly N step strobes, each one clock wide. `seek_done` rises in the same cycle as the last strobe and stays high until the next start. With N = 0, `seek_done` is high one cycle after the start and no strobe is issued.
- R4: A `rw_req` while the head is released raises `head_load` in the next cycle. `rw_ready` follows after 2 × engage-code ticks, with code 0 counting as 128. The measured delay may be up to one tick shorter.
- R5: After `rw_end`, `rw_ready` drops in the next cycle. `head_load` drops after 16 × release-code ticks, with code 0 counting as 16. The measured delay may be up to one tick shorter.
- R6: A `rw_req` that arrives while the release delay is still pending cancels the release. `rw_ready` is then high in the next cycle, and `head_load` never drops.
- R7: `nodma_mode` shows the transfer-mode bit from the last `cfg_wr`, where 1 means non-DMA and 0 means DMA. It changes at no other time.
- R8: During reset and after it, all outputs are 0 and all stored codes are 0.
- R9: `rw_ready` is only ever high while `head_load` is high. Once raised, it stays high until `rw_end`.
- R10: The three delay codes are captured only on `cfg_wr`. Changing the code inputs without a write leaves every delay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 3 | Data-rate select that scales every interval |
| cfg_wr | input | 1 | Captures the codes and the mode bit |
| cfg_step_code | input | 4 | Stepping interval code |
| cfg_unload_code | input | 4 | Head release delay code |
| cfg_load_code | input | 7 | Head engage delay code |
| cfg_nodma | input | 1 | Transfer-mode bit: 1 = non-DMA, 0 = DMA |
| seek_start | input | 1 | Starts a seek of seek_count steps |
| seek_count | input | CNT_W | Number of steps to issue |
| rw_req | input | 1 | Read/write operation wants the head |
| rw_end | input | 1 | Read/write execution phase has finished |
| step_out | output | 1 | One-cycle step strobe |
| seek_done | output | 1 | Requested steps are complete |
| head_load | output | 1 | Head engage output |
| rw_ready | output | 1 | Engage delay has elapsed; transfer may begin |
| nodma_mode | output | 1 | Stored transfer-mode bit |

## Verification
The assertions assume that BASE_CYC is at least 1, which makes every tick period at least three cycles. Under that assumption, two ticks never come in adjacent cycles and two step strobes are never back to back. They also assume `rw_end` is pulsed only while `rw_ready` is high, and `rw_req` only while the head is released or in its release countdown. The bench keeps to this: every read/write cycle is a request, a wait for ready, then an end, and seeks are started only after the previous one has reported done.

// File: rtl/drv_timing_pkg.sv
package drv_timing_pkg;

  typedef enum logic [1:0] {
    HD_IDLE    = 2'd0,
    HD_LOADING = 2'd1,
    HD_ACTIVE  = 2'd2,
    HD_HOLD    = 2'd3
  } head_state_e;

  localparam int TMR_W = 9;

  // Tick period multiplier per rate select, in units of 1/12 of a fast unit
  function automatic logic [4:0] rate_mult(input logic [2:0] sel);
    case (sel)
      3'd0:    rate_mult = 5'd3;
      3'd1:    rate_mult = 5'd6;
      3'd2:    rate_mult = 5'd12;
      3'd3:    rate_mult = 5'd20;
      default: rate_mult = 5'd24;
    endcase
  endfunction

  // Step interval in ticks: 16 - code, code 0 gives 16
  function automatic logic [4:0] step_ticks(input logic [3:0] code);
    step_ticks = 5'd16 - {1'b0, code};
  endfunction

  // Release delay: 16 ticks per code step, code 0 counts as 16
  function automatic logic [TMR_W-1:0] unload_ticks(input logic [3:0] code);
    unload_ticks = (code == 4'd0) ? 9'd256 : {1'b0, code, 4'b0000};
  endfunction

  // Engage delay: 2 ticks per code step, code 0 counts as 128
  function automatic logic [TMR_W-1:0] load_ticks(input logic [6:0] code);
    load_ticks = (code == 7'd0) ? 9'd256 : {1'b0, code, 1'b0};
  endfunction

endpackage

// File: rtl/drv_prescaler.sv
module drv_prescaler #(
  parameter int BASE_CYC = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rate_sel,
  output logic       tick
);
  import drv_timing_pkg::*;

  localparam int MAX_PER = BASE_CYC * 24;
  localparam int PW      = $clog2(MAX_PER + 1);

  logic [PW-1:0] period;
  logic [PW-1:0] cnt;

  always_comb begin
    period = PW'(BASE_CYC * int'(rate_mult(rate_sel)));
  end

  assign tick = (cnt >= period - PW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + PW'(1);
    end
  end
endmodule

// File: rtl/drv_step_seq.sv
module drv_step_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  logic [4:0]       units,
  output logic             step,
  output logic             done,
  output logic             fire
);
  logic [CNT_W-1:0] remaining;
  logic [4:0]       tcnt;

  assign fire = !start && (remaining != '0) && tick && (tcnt == 5'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining <= '0;
      tcnt      <= '0;
      step      <= 1'b0;
      done      <= 1'b0;
    end else begin
      step <= 1'b0;
      if (start) begin
        remaining <= count;
        tcnt      <= units;
        done      <= (count == '0);
      end else if ((remaining != '0) && tick) begin
        if (fire) begin
          step      <= 1'b1;
          remaining <= remaining - CNT_W'(1);
          tcnt      <= units;
          if (remaining == CNT_W'(1)) done <= 1'b1;
        end else begin
          tcnt <= tcnt - 5'd1;
        end
      end
    end
  end
endmodule

// File: rtl/drv_head_ctrl.sv
module drv_head_ctrl
  import drv_timing_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rw_req,
  input  logic             rw_end,
  input  logic [TMR_W-1:0] load_n,
  input  logic [TMR_W-1:0] unload_n,
  output logic             head_load,
  output logic             rw_ready,
  output logic             load_expire,
  output logic             unload_expire
);
  head_state_e      state;
  logic [TMR_W-1:0] cnt;

  assign load_expire   = (state == HD_LOADING) && tick && (cnt == TMR_W'(1));
  assign unload_expire = (state == HD_HOLD) && !rw_req && tick && (cnt == TMR_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= HD_IDLE;
      cnt       <= '0;
      head_load <= 1'b0;
      rw_ready  <= 1'b0;
    end else begin
      case (state)
        HD_IDLE: if (rw_req) begin
          state     <= HD_LOADING;
          cnt       <= load_n;
          head_load <= 1'b1;
        end
        HD_LOADING: if (tick) begin
          if (load_expire) begin
            state    <= HD_ACTIVE;
            rw_ready <= 1'b1;
          end else begin
            cnt <= cnt - TMR_W'(1);
          end
        end
        HD_ACTIVE: if (rw_end) begin
          state    <= HD_HOLD;
          rw_ready <= 1'b0;
          cnt      <= unload_n;
        end
        HD_HOLD: begin
          if (rw_req) begin
            state    <= HD_ACTIVE;
            rw_ready <= 1'b1;
          end else if (tick) begin
            if (unload_expire) begin
              state     <= HD_IDLE;
              head_load <= 1'b0;
            end else begin
              cnt <= cnt - TMR_W'(1);
            end
          end
        end
        default: state <= HD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/drv_timing_seq.sv
module drv_timing_seq
  import drv_timing_pkg::*;
#(
  parameter int BASE_CYC = 500,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       rate_sel,
  input  logic             cfg_wr,
  input  logic [3:0]       cfg_step_code,
  input  logic [3:0]       cfg_unload_code,
  input  logic [6:0]       cfg_load_code,
  input  logic             cfg_nodma,
  input  logic             seek_start,
  input  logic [CNT_W-1:0] seek_count,
  input  logic             rw_req,
  input  logic             rw_end,
  output logic             step_out,
  output logic             seek_done,
  output logic             head_load,
  output logic             rw_ready,
  output logic             nodma_mode
);
  logic [3:0] step_code_q;
  logic [3:0] unload_code_q;
  logic [6:0] load_code_q;

  // Named internal events, visible to the bound checker
  logic tick_w;
  logic step_fire_w;
  logic load_expire_w;
  logic unload_expire_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_code_q   <= '0;
      unload_code_q <= '0;
      load_code_q   <= '0;
      nodma_mode    <= 1'b0;
    end else if (cfg_wr) begin
      step_code_q   <= cfg_step_code;
      unload_code_q <= cfg_unload_code;
      load_code_q   <= cfg_load_code;
      nodma_mode    <= cfg_nodma;
    end
  end

  drv_prescaler #(.BASE_CYC(BASE_CYC)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_sel (rate_sel),
    .tick     (tick_w)
  );

  drv_step_seq #(.CNT_W(CNT_W)) u_step (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_w),
    .start (seek_start),
    .count (seek_count),
    .units (step_ticks(step_code_q)),
    .step  (step_out),
    .done  (seek_done),
    .fire  (step_fire_w)
  );

  drv_head_ctrl u_head (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick_w),
    .rw_req        (rw_req),
    .rw_end        (rw_end),
    .load_n        (load_ticks(load_code_q)),
    .unload_n      (unload_ticks(unload_code_q)),
    .head_load     (head_load),
    .rw_ready      (rw_ready),
    .load_expire   (load_expire_w),
    .unload_expire (unload_expire_w)
  );
endmodule

// File: rtl/drv_timing_chk.sv
module drv_timing_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic step_fire,
  input logic step_out,
  input logic seek_done,
  input logic head_load,
  input logic rw_ready,
  input logic rw_end,
  input logic cfg_wr,
  input logic nodma_mode
);
  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R1

  AST_FIRE_TO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> step_out); // R2

  AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    step_out |=> !step_out); // R3

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (seek_done && $past(seek_done)) |-> !step_out); // R3

  AST_HEAD_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(head_load) |-> !$past(rw_ready)); // R5

  AST_NODMA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_wr) |-> $stable(nodma_mode)); // R7

  AST_READY_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    rw_ready |-> head_load); // R9

  AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_ready && !rw_end) |=> rw_ready); // R9
endmodule

bind drv_timing_seq drv_timing_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick_w),
  .step_fire  (step_fire_w),
  .step_out   (step_out),
  .seek_done  (seek_done),
  .head_load  (head_load),
  .rw_ready   (rw_ready),
  .rw_end     (rw_end),
  .cfg_wr     (cfg_wr),
  .nodma_mode (nodma_mode)
);

// File: tb/drv_timing_seq_test.sv
module drv_timing_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] rate_sel = 3'd0;
  logic       cfg_wr = 1'b0;
  logic [3:0] cfg_step_code = '0;
  logic [3:0] cfg_unload_code = '0;
  logic [6:0] cfg_load_code = '0;
  logic       cfg_nodma = 1'b0;
  logic       seek_start = 1'b0;
  logic [7:0] seek_count = '0;
  logic       rw_req = 1'b0;
  logic       rw_end = 1'b0;
  logic       step_out, seek_done, head_load, rw_ready, nodma_mode;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  drv_timing_seq #(.BASE_CYC(BASE), .CNT_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .cfg_wr(cfg_wr),
    .cfg_step_code(cfg_step_code), .cfg_unload_code(cfg_unload_code),
    .cfg_load_code(cfg_load_code), .cfg_nodma(cfg_nodma),
    .seek_start(seek_start), .seek_count(seek_count),
    .rw_req(rw_req), .rw_end(rw_end), .step_out(step_out),
    .seek_done(seek_done), .head_load(head_load), .rw_ready(rw_ready),
    .nodma_mode(nodma_mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Tick period from the data rate in kbps: 2000 kbps -> 3 base cycles
  function automatic int period_of(input int sel);
    int kbps;
    case (sel)
      0: kbps = 2000;
      1: kbps = 1000;
      2: kbps = 500;
      3: kbps = 300;
      default: kbps = 250;
    endcase
    return BASE * (6000 / kbps);
  endfunction

  task automatic write_cfg(input int s, input int u, input int l, input bit nd);
    @(negedge clk);
    cfg_step_code = 4'(s); cfg_unload_code = 4'(u); cfg_load_code = 7'(l);
    cfg_nodma = nd; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic run_seek(input int n, output int first, output int gap,
                          output int pulses, output bit done_ok);
    int t;
    int prev;
    bit early;
    first = -1; gap = -1; pulses = 0; prev = 0; early = 0; done_ok = 0;
    @(negedge clk);
    seek_count = 8'(n); seek_start = 1'b1;
    @(negedge clk);
    seek_start = 1'b0;
    t = 1;
    while (pulses < n && t < 5000) begin
      if (step_out) begin
        pulses++;
        if (first < 0) first = t; else gap = t - prev;
        prev = t;
        if (pulses == n) done_ok = seek_done && !early;
      end else if (seek_done) begin
        early = 1;
      end
      @(negedge clk);
      t++;
    end
  endtask

  task automatic head_cycle(output int dl, output int du, output bit hl_ok);
    int t;
    @(negedge clk);
    rw_req = 1'b1;
    @(negedge clk);
    rw_req = 1'b0;
    hl_ok = head_load;
    t = 1;
    while (!rw_ready && t < 20000) begin
      @(negedge clk);
      t++;
    end
    dl = t - 1;
    rw_end = 1'b1;
    @(negedge clk);
    rw_end = 1'b0;
    hl_ok = hl_ok && !rw_ready;
    t = 1;
    while (head_load && t < 20000) begin
      @(negedge clk);
      t++;
    end
    du = t - 1;
  endtask

  initial begin
    int first, gap, pulses, dl, du, n, p;
    bit dok, hok;
    int lcodes[4] = '{0, 1, 64, 127};
    int ucodes[3] = '{0, 1, 15};

    repeat (3) @(negedge clk);
    check(!step_out && !seek_done && !head_load && !rw_ready && !nodma_mode,
          "R8 outputs in reset", {step_out, seek_done, head_load, rw_ready, nodma_mode}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!step_out && !seek_done && !head_load && !rw_ready && !nodma_mode,
          "R8 outputs after reset", {step_out, seek_done, head_load, rw_ready, nodma_mode}, 0);

    // R2/R3: every stepping code at 2 Mbps
    for (int c = 0; c < 16; c++) begin
      write_cfg(c, 1, 1, 0);
      n = 16 - c; p = period_of(0);
      run_seek(3, first, gap, pulses, dok);
      check(pulses == 3, "R3 pulse count", pulses, 3);
      check(dok, "R3 done with last pulse", dok, 1);
      check(gap == n * p, "R2 step gap", gap, n * p);
      check(first >= (n - 1) * p + 2 && first <= n * p + 1, "R2 first step", first, n * p + 1);
    end

    // R1: tick period per rate select, measured with one-tick steps
    write_cfg(15, 1, 1, 0);
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      rate_sel = 3'(s);
      run_seek(3, first, gap, pulses, dok);
      check(gap == period_of(s), "R1 tick period", gap, period_of(s));
    end
    rate_sel = 3'd0;

    // R3: zero step count
    @(negedge clk);
    seek_count = 8'd0; seek_start = 1'b1;
    @(negedge clk);
    seek_start = 1'b0;
    check(seek_done, "R3 zero count done", seek_done, 1);
    pulses = 0;
    for (int i = 0; i < 60; i++) begin
      if (step_out) pulses++;
      @(negedge clk);
    end
    check(pulses == 0, "R3 zero count no strobe", pulses, 0);

    // R4: engage codes at 2 Mbps
    p = period_of(0);
    foreach (lcodes[i]) begin
      write_cfg(15, 1, lcodes[i], 0);
      n = 2 * ((lcodes[i] == 0) ? 128 : lcodes[i]);
      head_cycle(dl, du, hok);
      check(hok, "R4 head raised", hok, 1);
      check(dl >= (n - 1) * p + 1 && dl <= n * p, "R4 engage delay", dl, n * p);
    end

    // R5: release codes at 2 Mbps
    foreach (ucodes[i]) begin
      write_cfg(15, ucodes[i], 1, 0);
      n = 16 * ((ucodes[i] == 0) ? 16 : ucodes[i]);
      head_cycle(dl, du, hok);
      check(hok, "R5 ready drops on end", hok, 1);
      check(du >= (n - 1) * p + 1 && du <= n * p, "R5 release delay", du, n * p);
    end

    // R4 across rates
    write_cfg(15, 1, 3, 0);
    for (int s = 0; s < 5; s++) begin
      @(negedge clk);
      rate_sel = 3'(s);
      p = period_of(s);
      head_cycle(dl, du, hok);
      check(dl >= 5 * p + 1 && dl <= 6 * p, "R4 engage delay by rate", dl, 6 * p);
    end
    rate_sel = 3'd0;

    // R6: request during release countdown
    write_cfg(15, 4, 2, 0);
    head_cycle(dl, du, hok);
    @(negedge clk);
    rw_req = 1'b1;
    @(negedge clk);
    rw_req = 1'b0;
    while (!rw_ready) @(negedge clk);
    @(negedge clk);
    rw_end = 1'b1;
    @(negedge clk);
    rw_end = 1'b0;
    dok = 1;
    repeat (8) begin
      @(negedge clk);
      dok = dok && head_load;
    end
    rw_req = 1'b1;
    @(negedge clk);
    rw_req = 1'b0;
    check(rw_ready, "R6 immediate ready", rw_ready, 1);
    check(dok && head_load, "R6 head kept engaged", head_load, 1);
    rw_end = 1'b1;
    @(negedge clk);
    rw_end = 1'b0;
    while (head_load) @(negedge clk);

    // R10: code inputs without a write have no effect
    write_cfg(15, 1, 16, 0);
    @(negedge clk);
    cfg_load_code = 7'd2; cfg_unload_code = 4'd8;
    p = period_of(0);
    head_cycle(dl, du, hok);
    check(dl >= 31 * p + 1 && dl <= 32 * p, "R10 engage code held", dl, 32 * p);
    check(du >= 15 * p + 1 && du <= 16 * p, "R10 release code held", du, 16 * p);

    // R7: transfer-mode bit
    write_cfg(15, 1, 1, 1);
    @(negedge clk);
    check(nodma_mode, "R7 non-DMA stored", nodma_mode, 1);
    cfg_nodma = 1'b0;
    repeat (3) @(negedge clk);
    check(nodma_mode, "R7 mode held without write", nodma_mode, 1);
    write_cfg(15, 1, 1, 0);
    @(negedge clk);
    check(!nodma_mode, "R7 DMA stored", nodma_mode, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule